// File: doc/BRIEF.md
# Sleep and Wake Clock Sequencer

This block decides when the PLL that makes the system clock may run. Software asks for sleep by pulsing a strobe, which sets an internal sleep-request bit. From then on the PLL is held off and the clock output pin is gated. Only the always-on 32 kHz clock keeps running, so the real-time clock stays alive. Any of several wake lines ends the sleep. The PLL is switched back on, and the system clock is declared valid only after a fixed number of 32 kHz ticks. That number is chosen so that the system clock is usable within 2 ms of the wake event.

The sequencer has three states. RUN: the PLL is on and the system clock is valid. SLEEP: the PLL is off. WAKE_WAIT: the PLL is on and settling. The transitions are named as follows. RUN to SLEEP (enter_sleep) happens on the edge after the request bit is seen set. SLEEP to WAKE_WAIT (wake_seen) happens when a synchronised wake line is high. WAKE_WAIT to RUN (settle_done) happens after SETTLE_TICKS cycles, and it also clears the request bit. An asynchronous reset forces RUN from any state. The default is 62 ticks. Adding the two-stage wake synchroniser and the edge into WAKE_WAIT gives 65 ticks, about 1.98 ms, from the wake event to a valid clock.

Top module: `pll_sleep_seq`

## Requirements
- R1: While and after reset the block is in RUN: pll_en=1, sysclk_valid=1, sleep_flag=0, and the sleep-request bit is cleared.
- R2: In RUN, clko_en equals clko_en_req. In SLEEP and WAKE_WAIT, clko_en is 0 whatever clko_en_req is.
- R3: A sleep_set pulse sampled in RUN sets the request bit. The block enters SLEEP on the second rising edge after the pulse is driven.
- R4: In SLEEP the outputs are pll_en=0, sysclk_valid=0, clko_en=0 and sleep_flag=1, and they hold until a wake event or reset.
- R5: Wake lines have no effect in RUN.
- R6: In SLEEP, any wake_evt bit high for one cycle leads to WAKE_WAIT three rising edges after it is driven, through a two-flop synchroniser. WAKE_WAIT outputs are pll_en=1, sysclk_valid=0, clko_en=0 and sleep_flag=0.
- R7: WAKE_WAIT lasts exactly SETTLE_TICKS cycles (62 by default) before RUN.
- R8: Wake lines have no effect in WAKE_WAIT and do not restart the settling count.
- R9: The request bit is cleared on the settle_done transition, so the block stays in RUN afterwards.
- R10: sleep_set is ignored in SLEEP and WAKE_WAIT. This includes the last WAKE_WAIT cycle, whose edge performs settle_done.
- R11: An asynchronous reset asserted in SLEEP returns the block to RUN at once, and a later sleep and wake cycle works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lp | input | 1 | Always-on 32 kHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_set | input | 1 | One-cycle strobe that sets the sleep-request bit |
| wake_evt | input | WAKE_W | Wake event lines, asynchronous |
| clko_en_req | input | 1 | Software enable for the clock output pin |
| pll_en | output | 1 | PLL power enable |
| sysclk_valid | output | 1 | System clock is running and settled |
| clko_en | output | 1 | Gated enable for the clock output pin |
| sleep_flag | output | 1 | High while in SLEEP |

## Verification
Two actions can meet on one edge: a sleep_set strobe, and the settle_done transition that clears the request bit. The bench drives the strobe exactly in the last WAKE_WAIT cycle. It then expects RUN to persist, because the clear wins and a strobe is accepted only in RUN. A second strobe, placed one cycle later in RUN, must enter SLEEP two edges after it is driven. A wake pulse in the middle of WAKE_WAIT is also injected, and the bench judges that it does not move the RUN transition by even one cycle.

// File: rtl/pll_sleep_pkg.sv
package pll_sleep_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_SLEEP     = 2'd1,
        ST_WAKE_WAIT = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pll_sleep_wake_sync.sv
module pll_sleep_wake_sync #(
    parameter int WAKE_W = 4,
    parameter int STAGES = 2
) (
    input  logic              clk_lp,
    input  logic              rst_n,
    input  logic [WAKE_W-1:0] wake_async,
    output logic              wake_any
);
    logic [WAKE_W-1:0] synced;

    for (genvar i = 0; i < WAKE_W; i++) begin : g_line
        logic [STAGES-1:0] shreg;
        always_ff @(posedge clk_lp or negedge rst_n) begin
            if (!rst_n) shreg <= '0;
            else        shreg <= {shreg[STAGES-2:0], wake_async[i]};
        end
        assign synced[i] = shreg[STAGES-1];
    end

    assign wake_any = |synced;
endmodule

// File: rtl/pll_sleep_reqbit.sv
module pll_sleep_reqbit (
    input  logic clk_lp,
    input  logic rst_n,
    input  logic set_stb,
    input  logic accept,
    input  logic clear,
    output logic req_q
);
    always_ff @(posedge clk_lp or negedge rst_n) begin
        if (!rst_n)                   req_q <= 1'b0;
        else if (clear)               req_q <= 1'b0;
        else if (set_stb && accept)   req_q <= 1'b1;
    end
endmodule

// File: rtl/pll_sleep_settle_cnt.sv
module pll_sleep_settle_cnt #(
    parameter int SETTLE_TICKS = 62
) (
    input  logic clk_lp,
    input  logic rst_n,
    input  logic en,
    output logic done
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk_lp or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (!en)      cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == LAST);
endmodule

// File: rtl/pll_sleep_seq.sv
module pll_sleep_seq
    import pll_sleep_pkg::*;
#(
    parameter int WAKE_W       = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int SETTLE_TICKS = 62
) (
    input  logic              clk_lp,
    input  logic              rst_n,
    input  logic              sleep_set,
    input  logic [WAKE_W-1:0] wake_evt,
    input  logic              clko_en_req,
    output logic              pll_en,
    output logic              sysclk_valid,
    output logic              clko_en,
    output logic              sleep_flag
);
    seq_state_e state_q, state_d;
    logic wake_any, req_q, settle_done, req_clear;

    pll_sleep_wake_sync #(.WAKE_W(WAKE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_lp     (clk_lp),
        .rst_n      (rst_n),
        .wake_async (wake_evt),
        .wake_any   (wake_any)
    );

    pll_sleep_reqbit u_req (
        .clk_lp  (clk_lp),
        .rst_n   (rst_n),
        .set_stb (sleep_set),
        .accept  (state_q == ST_RUN),
        .clear   (req_clear),
        .req_q   (req_q)
    );

    pll_sleep_settle_cnt #(.SETTLE_TICKS(SETTLE_TICKS)) u_cnt (
        .clk_lp (clk_lp),
        .rst_n  (rst_n),
        .en     (state_q == ST_WAKE_WAIT),
        .done   (settle_done)
    );

    assign req_clear = (state_q == ST_WAKE_WAIT) && settle_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (req_q)       state_d = ST_SLEEP;
            ST_SLEEP:     if (wake_any)    state_d = ST_WAKE_WAIT;
            ST_WAKE_WAIT: if (settle_done) state_d = ST_RUN;
            default:                       state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_lp or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        pll_en       = 1'b1;
        sysclk_valid = 1'b0;
        clko_en      = 1'b0;
        sleep_flag   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                sysclk_valid = 1'b1;
                clko_en      = clko_en_req;
            end
            ST_SLEEP: begin
                pll_en     = 1'b0;
                sleep_flag = 1'b1;
            end
            ST_WAKE_WAIT: begin
                pll_en = 1'b1;
            end
            default: begin
                pll_en = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pll_sleep_seq_chk.sv
module pll_sleep_seq_chk #(
    parameter int SETTLE_TICKS = 62
) (
    input logic clk_lp,
    input logic rst_n,
    input logic pll_en,
    input logic sysclk_valid,
    input logic clko_en,
    input logic sleep_flag
);
    int settle_seen;

    always_ff @(posedge clk_lp or negedge rst_n) begin
        if (!rst_n)                      settle_seen <= 0;
        else if (pll_en && !sysclk_valid) settle_seen <= settle_seen + 1;
        else                              settle_seen <= 0;
    end

    // R4
    sleep_outputs_chk: assert property (@(posedge clk_lp) disable iff (!rst_n)
        sleep_flag |-> (!pll_en && !sysclk_valid && !clko_en));

    // R2
    clko_gated_chk: assert property (@(posedge clk_lp) disable iff (!rst_n)
        clko_en |-> sysclk_valid);

    // R3
    sleep_from_run_chk: assert property (@(posedge clk_lp) disable iff (!rst_n)
        $rose(sleep_flag) |-> $past(sysclk_valid));

    // R7
    settle_len_chk: assert property (@(posedge clk_lp) disable iff (!rst_n)
        $rose(sysclk_valid) |-> (settle_seen == SETTLE_TICKS));

    // R7
    settle_bound_chk: assert property (@(posedge clk_lp) disable iff (!rst_n)
        (pll_en && !sysclk_valid) |-> (settle_seen < SETTLE_TICKS));
endmodule

bind pll_sleep_seq pll_sleep_seq_chk #(.SETTLE_TICKS(SETTLE_TICKS)) u_chk (
    .clk_lp       (clk_lp),
    .rst_n        (rst_n),
    .pll_en       (pll_en),
    .sysclk_valid (sysclk_valid),
    .clko_en      (clko_en),
    .sleep_flag   (sleep_flag)
);

// File: tb/pll_sleep_seq_tb.sv
module pll_sleep_seq_tb;
    localparam int WAKE_W = 4;
    localparam int SETTLE = 62;
    localparam logic [3:0] T_RUN1 = 4'b1110, T_RUN0 = 4'b1100,
                           T_SLP  = 4'b0001, T_WW   = 4'b1000;

    logic clk_lp = 1'b0, rst_n = 1'b0, sleep_set = 1'b0, clko_en_req = 1'b0;
    logic [WAKE_W-1:0] wake_evt = '0;
    logic pll_en, sysclk_valid, clko_en, sleep_flag;

    pll_sleep_seq #(.WAKE_W(WAKE_W), .SETTLE_TICKS(SETTLE)) u_dut (
        .clk_lp(clk_lp), .rst_n(rst_n), .sleep_set(sleep_set), .wake_evt(wake_evt),
        .clko_en_req(clko_en_req), .pll_en(pll_en), .sysclk_valid(sysclk_valid),
        .clko_en(clko_en), .sleep_flag(sleep_flag)
    );

    always #4 clk_lp = ~clk_lp;

    int cyc = 0, checks = 0, errors = 0;
    bit done = 0, mon_on = 0;
    int         qc[$];
    logic [3:0] qt[$];
    string      qr[$];
    logic [3:0] prev;

    always @(posedge clk_lp) cyc <= cyc + 1;

    function automatic logic [3:0] tup();
        return {pll_en, sysclk_valid, clko_en, sleep_flag};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int c, input logic [3:0] t, input string r);
        qc.push_back(c); qt.push_back(t); qr.push_back(r);
    endtask

    task automatic goto(input int c);
        while (cyc < c) @(negedge clk_lp);
    endtask

    task automatic pulse_sleep();
        sleep_set = 1'b1; @(negedge clk_lp); sleep_set = 1'b0;
    endtask

    task automatic pulse_wake(input int bitn);
        wake_evt[bitn] = 1'b1; @(negedge clk_lp); wake_evt = '0;
    endtask

    // Monitor: pops expected changes and compares value and cycle.
    always @(posedge clk_lp) begin
        #2;
        if (mon_on) begin
            logic [3:0] cur;
            cur = tup();
            if (qc.size() > 0 && cyc > qc[0] && cur === prev) begin
                chk(1'b0, {qr[0], " missed change"}, cur, qt[0]);
                void'(qc.pop_front()); void'(qt.pop_front()); void'(qr.pop_front());
            end
            if (cur !== prev) begin
                if (qc.size() == 0) begin
                    chk(1'b0, "unexpected change", cur, prev);
                end else begin
                    int c; logic [3:0] t; string r;
                    c = qc.pop_front(); t = qt.pop_front(); r = qr.pop_front();
                    if (c != cyc)
                        $display("FAIL %s: change at cycle %0d expected cycle %0d", r, cyc, c);
                    checks++;
                    if (c != cyc) errors++;
                    chk(t === cur, r, cur, t);
                end
                prev = cur;
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk_lp);
        chk(tup() === T_RUN0, "R1 reset state", tup(), T_RUN0);
        rst_n = 1'b1;
        @(negedge clk_lp);
        chk(tup() === T_RUN0, "R1 after release", tup(), T_RUN0);
        prev = tup(); mon_on = 1;

        // R2 clock output follows request in RUN
        n = cyc; clko_en_req = 1'b1; expect_at(n + 1, T_RUN1, "R2 clko on");
        repeat (3) @(negedge clk_lp);
        n = cyc; clko_en_req = 1'b0; expect_at(n + 1, T_RUN0, "R2 clko off");
        repeat (3) @(negedge clk_lp);
        n = cyc; clko_en_req = 1'b1; expect_at(n + 1, T_RUN1, "R2 clko on again");
        repeat (3) @(negedge clk_lp);

        // R5 wake ignored in RUN
        pulse_wake(1);
        repeat (10) @(negedge clk_lp);
        chk(tup() === T_RUN1, "R5 wake in RUN", tup(), T_RUN1);

        // R3, R4 enter sleep
        n = cyc; expect_at(n + 2, T_SLP, "R3 enter sleep"); pulse_sleep();
        repeat (40) @(negedge clk_lp);
        chk(tup() === T_SLP, "R4 sleep held, R2 clko gated", tup(), T_SLP);

        // R6, R7, R8, R10 wake cycle with stray strobes and wakes
        n = cyc;
        expect_at(n + 3, T_WW, "R6 wake wait");
        expect_at(n + 3 + SETTLE, T_RUN1, "R7 settle length, R8 wake ignored");
        pulse_wake(2);
        goto(n + 10); pulse_sleep();          // R10 strobe in WAKE_WAIT
        goto(n + 20); pulse_wake(0);          // R8 wake in WAKE_WAIT
        goto(n + 2 + SETTLE); pulse_sleep();  // R10 strobe on settle_done edge
        goto(n + 3 + SETTLE + 40);
        chk(tup() === T_RUN1, "R9 R10 stays in RUN", tup(), T_RUN1);

        // sleep again, then wake and strobe right after RUN (R3 boundary)
        n = cyc; expect_at(n + 2, T_SLP, "R3 second sleep"); pulse_sleep();
        repeat (20) @(negedge clk_lp);
        n = cyc;
        expect_at(n + 3, T_WW, "R6 wake line 3");
        expect_at(n + 3 + SETTLE, T_RUN1, "R7 settle second");
        pulse_wake(3);
        goto(n + 3 + SETTLE);
        expect_at(n + 5 + SETTLE, T_SLP, "R3 strobe first RUN cycle");
        pulse_sleep();
        repeat (10) @(negedge clk_lp);

        // R11 reset in SLEEP
        n = cyc; rst_n = 1'b0; expect_at(n + 1, T_RUN1, "R11 reset from sleep");
        repeat (3) @(negedge clk_lp);
        rst_n = 1'b1;
        repeat (10) @(negedge clk_lp);
        chk(tup() === T_RUN1, "R11 RUN after reset", tup(), T_RUN1);
        n = cyc; expect_at(n + 2, T_SLP, "R11 sleep after reset"); pulse_sleep();
        repeat (5) @(negedge clk_lp);
        n = cyc;
        expect_at(n + 3, T_WW, "R11 wake after reset");
        expect_at(n + 3 + SETTLE, T_RUN1, "R11 run after reset");
        pulse_wake(0);
        goto(n + SETTLE + 10);

        while (qc.size() > 0) begin
            chk(1'b0, {qr[0], " never seen"}, tup(), qt[0]);
            void'(qc.pop_front()); void'(qt.pop_front()); void'(qr.pop_front());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_lp);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule